// File: doc/BRIEF.md
# SDRAM Auto-Precharge Write Sequencer

This block sits between a simple host write port and a two-bank SDRAM. Each accepted request names a bank, a row, a column and a data word. The block opens the row, issues one burst write that closes the row by itself, and drives the burst beats on the data pins. Beat i carries the request word plus i. Between commands it keeps the chip selected and issues NOP. After a self-closing write it holds every new command back for the combined write-recovery and precharge interval, counted from the final beat.

After reset the block waits a short power-up interval and then programs the mode register, because its contents are undefined. The host can reprogram the mode later through a separate configuration port, and that port wins over a write request in the same cycle. The low three mode bits select the burst length. When full-page bursts are selected the write goes out without auto-precharge and the bank stays open. The block precharges that bank before its next command, whether that is an activate or a mode register write.

Top module: `sdram_wap_seq`

## Requirements
- R1: During and after reset the pins show NOP and both ready outputs stay low. The first command is a mode register write carrying INIT_MODE (default 0x021) with bank select 0.
- R2: A write with auto-precharge is encoded as RAS# high, CAS# low, WE# low. A10 is high, A7..A0 carry the column, the other address bits are 0 and BA carries the request bank.
- R3: An activate is encoded as RAS# low, CAS# high, WE# high, with the row on the address and the bank on BA. The write follows exactly T_RCD cycles later.
- R4: The data output enable is high on the write-command cycle and on each of the next BL-1 cycles, and low otherwise. Beat i drives request data + i, modulo 2^DATA_W.
- R5: After an auto-precharge write, the next command comes no earlier than (BL-1)+T_WR+T_RP cycles after it. With a request already waiting, it comes exactly then.
- R6: reqReady goes low in the cycle after a request is accepted and stays low through the recovery interval.
- R7: Mode bits [2:0] select the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, 111 gives full page (2^COL_W beats). Any other code gives 1.
- R8: In full-page mode the write has A10 low and the bank stays open. The next command is a precharge with RAS# low, CAS# high, WE# low, A10 low and BA set to the open bank. It comes no earlier than (BL-1)+T_WR cycles after the write, and the following command comes exactly T_RP cycles after the precharge.
- R9: A mode register write has RAS#, CAS# and WE# all low, the new value on A11..A0 and BA 0. It is issued only with both banks idle, and the next command comes at least 3 cycles later.
- R10: While cfgValid is high, reqReady is low, so a configuration request is served before a write request presented in the same cycle.
- R11: Every cycle without a command is a NOP with chip select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Write request valid |
| reqReady | output | 1 | Write request accepted when high with reqValid |
| reqBank | input | 1 | Target bank |
| reqRow | input | ROW_W | Row address |
| reqCol | input | COL_W | Starting column |
| reqData | input | DATA_W | First beat data |
| cfgValid | input | 1 | Mode reprogram request valid |
| cfgReady | output | 1 | Mode request accepted when high with cfgValid |
| cfgMode | input | MODE_W | New mode register value |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | 1 | Bank select |
| sdAddr | output | ROW_W | Address pins |
| sdDq | output | DATA_W | Write data |
| sdDqOe | output | 1 | Data output enable |

## Verification
The assertions check on every cycle that no command arrives inside the recovery window after a self-closing write, and that each write comes T_RCD cycles after its activate. They also check that the output enable covers the write command and that only NOPs appear during the trailing beats. A10 must match the active burst mode, a mode write must never find an open bank, and reqReady must stay low while a configuration request is pending. Only the bench scenarios can show the exact data of each beat, the back-to-back gap lengths, the lazy precharge that follows a full-page write, the reserved burst code, and the order of commands when both ports request at once.

// File: rtl/sdram_wap_pkg.sv
package sdram_wap_pkg;
  // {RAS#, CAS#, WE#}
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_NOP = 3'b111
  } sdCmd_e;

  typedef struct packed {
    logic   latchReq;
    logic   latchCfg;
    sdCmd_e cmd;
    logic   autoPre;
    logic   preBank;
    logic   dataBeat;
  } seqStrobe_t;
endpackage

// File: rtl/sdram_wap_ctrl.sv
module sdram_wap_ctrl
  import sdram_wap_pkg::*;
#(
  parameter int COL_W    = 8,
  parameter int T_WR     = 2,
  parameter int T_RP     = 3,
  parameter int T_RCD    = 3,
  parameter int INIT_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqBank,
  input  logic       cfgValid,
  input  logic [2:0] blCode,
  output logic       reqReady,
  output logic       cfgReady,
  output seqStrobe_t strobe
);
  localparam int T_DAL  = T_WR + T_RP;
  localparam int MAX_A  = (INIT_CYC > T_DAL) ? INIT_CYC : T_DAL;
  localparam int MAX_W  = (MAX_A > T_RCD) ? MAX_A : T_RCD;
  localparam int CNT_W  = $clog2(MAX_W + 1);
  localparam int BEAT_W = COL_W + 1;

  typedef enum logic [3:0] {
    S_INIT, S_MRS, S_MRS_GAP, S_IDLE, S_PRE, S_PRE_GAP,
    S_ACT, S_ACT_GAP, S_WR, S_BURST
  } state_e;

  state_e state;
  logic [CNT_W-1:0]  waitCnt, gapCnt;
  logic [BEAT_W-1:0] beatLeft, burstBeats;
  logic fullPage, openValid, openBank, curBank, nextIsCfg, idleFree;

  always_comb begin
    fullPage = (blCode == 3'd7);
    case (blCode)
      3'd1:    burstBeats = BEAT_W'(2);
      3'd2:    burstBeats = BEAT_W'(4);
      3'd3:    burstBeats = BEAT_W'(8);
      3'd7:    burstBeats = BEAT_W'(1) << COL_W;
      default: burstBeats = BEAT_W'(1);
    endcase
  end

  assign idleFree = (state == S_IDLE) && (gapCnt == '0);
  assign cfgReady = idleFree;
  assign reqReady = idleFree && !cfgValid;

  always_comb begin
    strobe = '{latchReq: 1'b0, latchCfg: 1'b0, cmd: CMD_NOP,
               autoPre: 1'b0, preBank: 1'b0, dataBeat: 1'b0};
    case (state)
      S_IDLE: begin
        strobe.latchCfg = cfgValid && idleFree;
        strobe.latchReq = reqValid && reqReady;
      end
      S_MRS: strobe.cmd = CMD_MRS;
      S_PRE: begin
        strobe.cmd     = CMD_PRE;
        strobe.preBank = openBank;
      end
      S_ACT: strobe.cmd = CMD_ACT;
      S_WR: begin
        strobe.cmd      = CMD_WR;
        strobe.autoPre  = !fullPage;
        strobe.dataBeat = 1'b1;
      end
      S_BURST: strobe.dataBeat = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_INIT;
      waitCnt   <= CNT_W'(INIT_CYC - 1);
      gapCnt    <= '0;
      beatLeft  <= '0;
      openValid <= 1'b0;
      openBank  <= 1'b0;
      curBank   <= 1'b0;
      nextIsCfg <= 1'b0;
    end else begin
      if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
      case (state)
        S_INIT: begin
          if (waitCnt == '0) state <= S_MRS;
          else waitCnt <= waitCnt - 1'b1;
        end
        S_MRS:     state <= S_MRS_GAP;
        S_MRS_GAP: state <= S_IDLE;
        S_IDLE: begin
          if (cfgValid && idleFree) begin
            nextIsCfg <= 1'b1;
            state     <= openValid ? S_PRE : S_MRS;
          end else if (reqValid && reqReady) begin
            nextIsCfg <= 1'b0;
            curBank   <= reqBank;
            state     <= openValid ? S_PRE : S_ACT;
          end
        end
        S_PRE: begin
          openValid <= 1'b0;
          waitCnt   <= CNT_W'(T_RP - 2);
          state     <= S_PRE_GAP;
        end
        S_PRE_GAP: begin
          if (waitCnt == '0) state <= nextIsCfg ? S_MRS : S_ACT;
          else waitCnt <= waitCnt - 1'b1;
        end
        S_ACT: begin
          waitCnt <= CNT_W'(T_RCD - 2);
          state   <= S_ACT_GAP;
        end
        S_ACT_GAP: begin
          if (waitCnt == '0) state <= S_WR;
          else waitCnt <= waitCnt - 1'b1;
        end
        S_WR: begin
          if (burstBeats == BEAT_W'(1)) begin
            gapCnt <= CNT_W'(T_DAL - 2);
            state  <= S_IDLE;
          end else begin
            beatLeft <= burstBeats - BEAT_W'(2);
            state    <= S_BURST;
          end
        end
        S_BURST: begin
          if (beatLeft == '0) begin
            gapCnt <= fullPage ? CNT_W'(T_WR - 2) : CNT_W'(T_DAL - 2);
            if (fullPage) begin
              openValid <= 1'b1;
              openBank  <= curBank;
            end
            state <= S_IDLE;
          end else begin
            beatLeft <= beatLeft - 1'b1;
          end
        end
        default: state <= S_INIT;
      endcase
    end
  end
endmodule

// File: rtl/sdram_wap_dp.sv
module sdram_wap_dp
  import sdram_wap_pkg::*;
#(
  parameter int              ROW_W     = 12,
  parameter int              COL_W     = 8,
  parameter int              DATA_W    = 16,
  parameter int              MODE_W    = 12,
  parameter logic [MODE_W-1:0] INIT_MODE = 12'h021
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqData,
  input  logic [MODE_W-1:0] cfgMode,
  output logic [2:0]        blCode,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              sdBa,
  output logic [ROW_W-1:0]  sdAddr,
  output logic [DATA_W-1:0] sdDq,
  output logic              sdDqOe
);
  localparam int AP_BIT = 10;

  logic              latBank;
  logic [ROW_W-1:0]  latRow, wrAddr;
  logic [COL_W-1:0]  latCol;
  logic [DATA_W-1:0] beatData;
  logic [MODE_W-1:0] pendMode;

  assign sdCsN = 1'b0;

  always_comb begin
    wrAddr              = '0;
    wrAddr[COL_W-1:0]   = latCol;
    wrAddr[AP_BIT]      = strobe.autoPre;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latBank  <= 1'b0;
      latRow   <= '0;
      latCol   <= '0;
      beatData <= '0;
      pendMode <= INIT_MODE;
      blCode   <= '0;
    end else begin
      if (strobe.latchReq) begin
        latBank  <= reqBank;
        latRow   <= reqRow;
        latCol   <= reqCol;
        beatData <= reqData;
      end else if (strobe.dataBeat) begin
        beatData <= beatData + 1'b1;
      end
      if (strobe.latchCfg) pendMode <= cfgMode;
      if (strobe.cmd == CMD_MRS) blCode <= pendMode[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {sdRasN, sdCasN, sdWeN} <= 3'b111;
      sdBa   <= 1'b0;
      sdAddr <= '0;
      sdDq   <= '0;
      sdDqOe <= 1'b0;
    end else begin
      {sdRasN, sdCasN, sdWeN} <= strobe.cmd;
      case (strobe.cmd)
        CMD_ACT: begin sdBa <= latBank;        sdAddr <= latRow;          end
        CMD_WR:  begin sdBa <= latBank;        sdAddr <= wrAddr;          end
        CMD_PRE: begin sdBa <= strobe.preBank; sdAddr <= '0;              end
        CMD_MRS: begin sdBa <= 1'b0;           sdAddr <= ROW_W'(pendMode); end
        default: begin sdBa <= 1'b0;           sdAddr <= '0;              end
      endcase
      sdDqOe <= strobe.dataBeat;
      sdDq   <= strobe.dataBeat ? beatData : '0;
    end
  end
endmodule

// File: rtl/sdram_wap_seq.sv
module sdram_wap_seq
  import sdram_wap_pkg::*;
#(
  parameter int              ROW_W     = 12,
  parameter int              COL_W     = 8,
  parameter int              DATA_W    = 16,
  parameter int              MODE_W    = 12,
  parameter int              T_WR      = 2,
  parameter int              T_RP      = 3,
  parameter int              T_RCD     = 3,
  parameter int              INIT_CYC  = 4,
  parameter logic [MODE_W-1:0] INIT_MODE = 12'h021
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqData,
  input  logic              cfgValid,
  output logic              cfgReady,
  input  logic [MODE_W-1:0] cfgMode,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              sdBa,
  output logic [ROW_W-1:0]  sdAddr,
  output logic [DATA_W-1:0] sdDq,
  output logic              sdDqOe
);
  seqStrobe_t strobe;
  logic [2:0] blCode;

  sdram_wap_ctrl #(
    .COL_W(COL_W), .T_WR(T_WR), .T_RP(T_RP), .T_RCD(T_RCD), .INIT_CYC(INIT_CYC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBank(reqBank),
    .cfgValid(cfgValid), .blCode(blCode), .reqReady(reqReady),
    .cfgReady(cfgReady), .strobe(strobe)
  );

  sdram_wap_dp #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .MODE_W(MODE_W), .INIT_MODE(INIT_MODE)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqBank(reqBank), .reqRow(reqRow),
    .reqCol(reqCol), .reqData(reqData), .cfgMode(cfgMode), .blCode(blCode),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBa(sdBa),
    .sdAddr(sdAddr), .sdDq(sdDq), .sdDqOe(sdDqOe)
  );
endmodule

// File: rtl/sdram_wap_chk.sv
module sdram_wap_chk #(
  parameter int COL_W = 8,
  parameter int T_WR  = 2,
  parameter int T_RP  = 3,
  parameter int T_RCD = 3
) (
  input logic       clk,
  input logic       rstN,
  input logic       sdRasN,
  input logic       sdCasN,
  input logic       sdWeN,
  input logic       sdBa,
  input logic       addrAp,
  input logic [2:0] addrBl,
  input logic       sdDqOe,
  input logic       cfgValid,
  input logic       reqReady
);
  localparam int CW = 16;
  logic [2:0]    cmdNow;
  logic [CW-1:0] sinceAct, sinceAp, blCur, needAp;
  logic          apPending, fpMode;
  logic [1:0]    bankOpen;

  assign cmdNow = {sdRasN, sdCasN, sdWeN};
  assign needAp = blCur - 1'b1 + CW'(T_WR + T_RP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAct  <= '0;
      sinceAp   <= '0;
      apPending <= 1'b0;
      bankOpen  <= '0;
      blCur     <= CW'(1);
      fpMode    <= 1'b0;
    end else begin
      if (sinceAct != '1) sinceAct <= sinceAct + 1'b1;
      if (sinceAp != '1)  sinceAp  <= sinceAp + 1'b1;
      if (cmdNow != 3'b111) apPending <= 1'b0;
      case (cmdNow)
        3'b011: begin sinceAct <= CW'(1); bankOpen[sdBa] <= 1'b1; end
        3'b100: if (addrAp) begin
          apPending <= 1'b1;
          sinceAp   <= CW'(1);
          bankOpen[sdBa] <= 1'b0;
        end
        3'b010: bankOpen[sdBa] <= 1'b0;
        3'b000: begin
          fpMode <= (addrBl == 3'd7);
          case (addrBl)
            3'd1:    blCur <= CW'(2);
            3'd2:    blCur <= CW'(4);
            3'd3:    blCur <= CW'(8);
            3'd7:    blCur <= CW'(1) << COL_W;
            default: blCur <= CW'(1);
          endcase
        end
        default: ;
      endcase
    end
  end

  assert_recovery_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (apPending && cmdNow != 3'b111) |-> (sinceAp >= needAp));
  assert_act_to_wr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdNow == 3'b100) |-> (sinceAct == CW'(T_RCD)));
  assert_wr_drives_dq_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdNow == 3'b100) |-> sdDqOe);
  assert_beats_are_nop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sdDqOe && cmdNow != 3'b100) |-> (cmdNow == 3'b111));
  assert_mrs_banks_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdNow == 3'b000) |-> (bankOpen == 2'b00));
  assert_ap_matches_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdNow == 3'b100) |-> (addrAp == !fpMode));
  assert_cfg_first_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> !reqReady);
endmodule

bind sdram_wap_seq sdram_wap_chk #(
  .COL_W(COL_W), .T_WR(T_WR), .T_RP(T_RP), .T_RCD(T_RCD)
) i_chk (
  .clk(clk), .rstN(rstN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
  .sdBa(sdBa), .addrAp(sdAddr[10]), .addrBl(sdAddr[2:0]), .sdDqOe(sdDqOe),
  .cfgValid(cfgValid), .reqReady(reqReady)
);

// File: tb/test_sdram_wap_seq.sv
module test_sdram_wap_seq;
  localparam int ROW_W = 12, COL_W = 8, DATA_W = 16, MODE_W = 12;
  localparam int T_WR = 2, T_RP = 3, T_RCD = 3, INIT_CYC = 4;
  localparam int T_DAL = T_WR + T_RP;
  localparam logic [MODE_W-1:0] INIT_MODE = 12'h021;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqBank = 1'b0, cfgValid = 1'b0;
  logic [ROW_W-1:0] reqRow = '0;
  logic [COL_W-1:0] reqCol = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic [MODE_W-1:0] cfgMode = '0;
  logic reqReady, cfgReady, sdCsN, sdRasN, sdCasN, sdWeN, sdBa, sdDqOe;
  logic [ROW_W-1:0] sdAddr;
  logic [DATA_W-1:0] sdDq;

  always #2 clk = ~clk;

  sdram_wap_seq #(.INIT_MODE(INIT_MODE)) i_sdram_wap_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .reqData(reqData),
    .cfgValid(cfgValid), .cfgReady(cfgReady), .cfgMode(cfgMode),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdBa(sdBa), .sdAddr(sdAddr), .sdDq(sdDq), .sdDqOe(sdDqOe)
  );

  typedef struct {
    logic [2:0] cmd; logic ba; logic [ROW_W-1:0] addr;
    int gap; bit exact; string tag;
  } expCmd_t;
  typedef struct { logic [DATA_W-1:0] data; string tag; } expData_t;

  expCmd_t  cmdQ[$];
  expData_t dataQ[$];
  int total = 0, bad = 0, cyc = 0, lastCmd = 0;
  int lead = 0;
  logic [2:0] curCode = 3'd1;
  bit openTb = 0; logic openBankTb = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int beats(input logic [2:0] code);
    case (code)
      3'd1: return 2; 3'd2: return 4; 3'd3: return 8;
      3'd7: return 1 << COL_W;
      default: return 1;
    endcase
  endfunction

  task automatic pushCmd(input logic [2:0] c, input logic b, input logic [ROW_W-1:0] a,
                         input int g, input bit ex, input string tag);
    expCmd_t e;
    e.cmd = c; e.ba = b; e.addr = a; e.gap = g; e.exact = ex; e.tag = tag;
    cmdQ.push_back(e);
  endtask

  task automatic expWrite(input logic bank, input logic [ROW_W-1:0] row,
                          input logic [COL_W-1:0] col, input logic [DATA_W-1:0] d,
                          input bit b2b, input string dtag);
    int n; bit fp; logic [ROW_W-1:0] wa; expData_t x;
    n = beats(curCode); fp = (curCode == 3'd7);
    if (openTb) begin
      pushCmd(3'b010, openBankTb, '0, lead, b2b, "R8");
      pushCmd(3'b011, bank, row, T_RP, 1, "R8");
      openTb = 0;
    end else pushCmd(3'b011, bank, row, lead, b2b, "R5");
    wa = '0; wa[COL_W-1:0] = col; wa[10] = !fp;
    pushCmd(3'b100, bank, wa, T_RCD, 1, fp ? "R8" : "R2");
    for (int i = 0; i < n; i++) begin
      x.data = d + DATA_W'(i); x.tag = dtag; dataQ.push_back(x);
    end
    lead = fp ? (n - 1 + T_WR) : (n - 1 + T_DAL);
    if (fp) begin openTb = 1; openBankTb = bank; end
  endtask

  task automatic expCfg(input logic [MODE_W-1:0] m, input bit b2b);
    if (openTb) begin
      pushCmd(3'b010, openBankTb, '0, lead, b2b, "R8");
      pushCmd(3'b000, 1'b0, ROW_W'(m), T_RP, 1, "R9");
      openTb = 0;
    end else pushCmd(3'b000, 1'b0, ROW_W'(m), lead, b2b, "R9");
    lead = 3; curCode = m[2:0];
  endtask

  task automatic doWrite(input logic bank, input logic [ROW_W-1:0] row,
                         input logic [COL_W-1:0] col, input logic [DATA_W-1:0] d,
                         input bit b2b, input string dtag);
    expWrite(bank, row, col, d, b2b, dtag);
    reqValid = 1; reqBank = bank; reqRow = row; reqCol = col; reqData = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
    chk(reqReady == 0, "R6", "ready after accept", reqReady, 0);
  endtask

  task automatic doCfg(input logic [MODE_W-1:0] m, input bit b2b);
    expCfg(m, b2b);
    cfgValid = 1; cfgMode = m;
    while (!cfgReady) @(negedge clk);
    @(negedge clk);
    cfgValid = 0;
  endtask

  // monitor: pops expected items as the pins produce them
  always @(negedge clk) begin
    expCmd_t e; expData_t x; logic [2:0] c;
    cyc++;
    if (rstN) begin
      c = {sdRasN, sdCasN, sdWeN};
      if (c != 3'b111) begin
        chk(sdCsN == 1'b0, "R11", "cs on command", sdCsN, 0);
        if (cmdQ.size() == 0) chk(0, "R11", "unexpected command", c, 3'b111);
        else begin
          e = cmdQ.pop_front();
          chk(c == e.cmd, e.tag, "command code", c, e.cmd);
          chk(sdBa == e.ba, e.tag, "bank select", sdBa, e.ba);
          chk(sdAddr == e.addr, e.tag, "address", sdAddr, e.addr);
          if (e.gap > 0) begin
            if (e.exact) chk(cyc - lastCmd == e.gap, (e.cmd == 3'b100) ? "R3" : "R5",
                             "exact gap", cyc - lastCmd, e.gap);
            else chk(cyc - lastCmd >= e.gap, "R5", "minimum gap", cyc - lastCmd, e.gap);
          end
          lastCmd = cyc;
        end
      end else begin
        if (!sdDqOe && cmdQ.size() == 0 && dataQ.size() == 0)
          chk(sdCsN == 1'b0, "R11", "nop chip select", sdCsN, 0);
      end
      if (sdDqOe) begin
        if (dataQ.size() == 0) chk(0, "R4", "unexpected beat", sdDq, 0);
        else begin
          x = dataQ.pop_front();
          chk(sdDq == x.data, x.tag, "beat data", sdDq, x.data);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({sdRasN, sdCasN, sdWeN} == 3'b111 && sdCsN == 0, "R1", "reset pins nop",
        {sdCsN, sdRasN, sdCasN, sdWeN}, 4'b0111);
    chk(sdDqOe == 0, "R1", "reset oe", sdDqOe, 0);
    chk(reqReady == 0 && cfgReady == 0, "R1", "reset ready", {reqReady, cfgReady}, 0);
    pushCmd(3'b000, 1'b0, ROW_W'(INIT_MODE), 0, 0, "R1");
    lead = 3;
    rstN = 1;
    @(negedge clk);
    chk(reqReady == 0, "R1", "ready before init", reqReady, 0);

    // BL2 writes, second back-to-back: exact recovery gap (R5)
    doWrite(1'b0, 12'h123, 8'h45, 16'h1000, 0, "R4");
    doWrite(1'b1, 12'h0AB, 8'h10, 16'hFFFF, 1, "R4");
    // BL4, last column
    doCfg(12'h022, 0);
    doWrite(1'b1, 12'hFFF, 8'hFF, 16'h2000, 1, "R7");
    // BL8
    doCfg(12'h023, 0);
    doWrite(1'b0, 12'h001, 8'h00, 16'h3000, 1, "R7");
    // BL1, two back-to-back
    doCfg(12'h020, 0);
    doWrite(1'b0, 12'h010, 8'h20, 16'h4000, 1, "R7");
    doWrite(1'b1, 12'h011, 8'h21, 16'h4100, 1, "R5");
    // reserved burst code behaves as one beat (R7)
    doCfg(12'h024, 0);
    doWrite(1'b1, 12'h012, 8'h22, 16'h4200, 1, "R7");
    // full page: bank stays open, precharge on next request (R8)
    doCfg(12'h027, 0);
    doWrite(1'b0, 12'h200, 8'h00, 16'h5000, 1, "R8");
    doWrite(1'b1, 12'h201, 8'h80, 16'h6000, 1, "R8");
    // reconfig with bank 1 open: precharge then mode write (R9)
    doCfg(12'h022, 1);
    doWrite(1'b0, 12'h300, 8'h30, 16'h7000, 1, "R4");

    // R10: both ports request in the same cycle
    while (!cfgReady) @(negedge clk);
    expCfg(12'h021, 1);
    expWrite(1'b1, 12'h0CC, 8'h33, 16'h8000, 1, "R10");
    cfgValid = 1; cfgMode = 12'h021;
    reqValid = 1; reqBank = 1'b1; reqRow = 12'h0CC; reqCol = 8'h33; reqData = 16'h8000;
    #0;
    chk(reqReady == 0, "R10", "write held while cfg pending", reqReady, 0);
    @(negedge clk);
    cfgValid = 0;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;

    for (int k = 0; k < 400 && (cmdQ.size() != 0 || dataQ.size() != 0); k++)
      @(negedge clk);
    repeat (10) @(negedge clk);
    chk(cmdQ.size() == 0, "R2", "commands left", cmdQ.size(), 0);
    chk(dataQ.size() == 0, "R4", "beats left", dataQ.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule